// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a byte-wide SPI master. It has a transmit holding register in front of a transmit shift register, and a receive holding register behind a receive shift register. A byte can therefore be loaded while the previous one is still shifting, and a received byte stays readable while the next one arrives. It generates the serial clock from the system clock through a programmable divider. It drives the serial output, samples the serial input, and can optionally frame an active-low slave select by itself.

A mode input selects how consecutive bytes are framed.

- **Streaming mode:** at the end of every byte the sequencer checks whether the holding register is loaded. If it is, the next byte follows with no break in the serial clock. If it is not, the burst closes and slave select rises once.
- **Per-byte mode:** every byte is its own transfer, followed by a deselected idle period of at least one full serial clock period.

A transmit-empty flag tells software when to supply the next byte. A receive-ready flag and an overflow flag report on the receive side.

Top module: `spi_dbuf_master`

## Requirements
- R1: Each transfer moves exactly 8 bits, most significant bit first. `dout` changes only while `sclk` is low, and `din` is captured at each rising `sclk` edge.
- R2: `sclk` idles low. Every high and low phase inside a transfer lasts `cfg_div`+1 clock cycles, including the step from one byte to the next in streaming mode.
- R3: A write to the holding register while the block is idle starts a transfer. When `cfg_auto_ss`=1, `ss_n` goes low on the second rising clock edge after the write cycle. On that same edge `dout` shows bit 7 of the written byte.
- R4: When `cfg_auto_ss`=0, `ss_oe` is 0 and `ss_n` stays 1 throughout all traffic.
- R5: When `cfg_cont`=1, a byte written before the current byte ends follows with no clock break. `ss_n` rises exactly once per burst, after the last byte, when the holding register is found empty at a byte boundary.
- R6: When `cfg_cont`=0 and `cfg_auto_ss`=1, `ss_n` rises after every byte. It stays high, with `sclk` low, for at least 2×(`cfg_div`+1) cycles before the next byte.
- R7: `tx_empty_irq` is 0 after reset. It sets on the edge where the holding register moves into the shift register. It reads 0 from the edge after a `tx_wr`, and a write wins over a simultaneous move.
- R8: At the end of each byte the received byte appears on `rx_data` and `rx_ready` sets. A one-cycle `rx_rd` clears `rx_ready`.
- R9: A byte that completes while `rx_ready` is still set raises `rx_overflow` and replaces `rx_data`. `rx_rd` clears `rx_overflow`. `rx_overflow` implies `rx_ready`.
- R10: After reset, `ss_n`=1, `sclk`=0, `dout`=0, `busy`=0, and all three flags are 0.
- R11: `busy` is 1 from the edge after a `tx_wr` until the last transfer and its trailing deselect period are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cont | input | 1 | 1 = streaming mode, 0 = per-byte mode |
| cfg_auto_ss | input | 1 | 1 = block frames slave select by itself |
| cfg_div | input | DIV_W | Serial clock half period, in clock cycles, minus one |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W | Byte to write |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| din | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| dout | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| ss_oe | output | 1 | Drive enable for `ss_n` |
| busy | output | 1 | A transfer is pending or in progress |
| tx_empty_irq | output | 1 | Transmit holding register has been emptied |
| rx_data | output | DATA_W | Receive holding register |
| rx_ready | output | 1 | Unread received byte present |
| rx_overflow | output | 1 | A received byte was overwritten before it was read |

## Verification
A write is registered on the first edge. It reaches `ss_n`, `dout` and `tx_empty_irq` on the second edge. `sclk` then rises `cfg_div`+1 edges later, and the directed test samples each of these on the negative clock edge after the edge that should change it. The slave model samples `dout` on every observed rising `sclk` edge and updates `din` right after. It also measures every `sclk` phase and every deselect stretch in clock cycles against `cfg_div`+1. The stream drivers act only on flags already visible at a negative edge: a new byte follows `tx_empty_irq`, and a read follows `rx_ready`. Every flag check therefore allows for the one registered edge between strobe and flag.

// File: rtl/spi_dbm_pkg.sv
package spi_dbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/spi_dbm_clkdiv.sv
module spi_dbm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q >= div);
endmodule

// File: rtl/spi_dbm_shifter.sv
module spi_dbm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              stop,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic              dout,
  output logic [DATA_W-1:0] rx_byte,
  output logic              last_bit
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [CNT_W-1:0]  bit_q;
  logic              dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q <= '0;
      bit_q   <= '0;
      dout_q  <= 1'b0;
    end else if (load) begin
      tx_sh_q <= load_data;
      bit_q   <= '0;
      dout_q  <= load_data[DATA_W-1];
    end else if (stop) begin
      bit_q  <= '0;
      dout_q <= 1'b0;
    end else if (fall) begin
      bit_q   <= bit_q + 1'b1;
      tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      dout_q  <= tx_sh_q[DATA_W-2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh_q <= '0;
    end else if (rise) begin
      rx_sh_q <= {rx_sh_q[DATA_W-2:0], din};
    end
  end

  assign dout     = dout_q;
  assign rx_byte  = rx_sh_q;
  assign last_bit = (bit_q == LAST);
endmodule

// File: rtl/spi_dbm_rxbuf.sv
module spi_dbm_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overflow
);
  logic [DATA_W-1:0] data_q;
  logic              ready_q;
  logic              ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (push) begin
        data_q  <= push_data;
        ready_q <= 1'b1;
      end else if (rd) begin
        ready_q <= 1'b0;
      end
      if (rd) begin
        ovf_q <= 1'b0;
      end else if (push && ready_q) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign rx_data     = data_q;
  assign rx_ready    = ready_q;
  assign rx_overflow = ovf_q;
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cont,
  input  logic              cfg_auto_ss,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              din,
  output logic              sclk,
  output logic              dout,
  output logic              ss_n,
  output logic              ss_oe,
  output logic              busy,
  output logic              tx_empty_irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overflow
);
  seq_state_t        state_q;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              sclk_q;
  logic              ss_n_q;
  logic              gap_half_q;
  logic              irq_q;

  logic              tick;
  logic              rise;
  logic              fall;
  logic              last_bit;
  logic              byte_done;
  logic              start_load;
  logic              end_burst;
  logic [DATA_W-1:0] rx_byte;

  spi_dbm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (state_q != ST_IDLE),
    .div  (cfg_div),
    .tick (tick)
  );

  assign rise       = tick && (state_q == ST_SHIFT) && !sclk_q;
  assign fall       = tick && (state_q == ST_SHIFT) && sclk_q;
  assign byte_done  = fall && last_bit;
  assign start_load = ((state_q == ST_IDLE) && hold_full_q) ||
                      (byte_done && cfg_cont && hold_full_q);
  assign end_burst  = byte_done && !(cfg_cont && hold_full_q);

  spi_dbm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start_load),
    .load_data (hold_q),
    .stop      (end_burst),
    .rise      (rise),
    .fall      (fall),
    .din       (din),
    .dout      (dout),
    .rx_byte   (rx_byte),
    .last_bit  (last_bit)
  );

  spi_dbm_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .push        (byte_done),
    .push_data   (rx_byte),
    .rd          (rx_rd),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .rx_overflow (rx_overflow)
  );

  // Transmit holding register and its empty flag; a write wins over a move.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (tx_wr) begin
        hold_q      <= tx_data;
        hold_full_q <= 1'b1;
        irq_q       <= 1'b0;
      end else if (start_load) begin
        hold_full_q <= 1'b0;
        irq_q       <= 1'b1;
      end
    end
  end

  // Transfer sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sclk_q     <= 1'b0;
      ss_n_q     <= 1'b1;
      gap_half_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (hold_full_q) begin
            state_q <= ST_SHIFT;
            ss_n_q  <= !cfg_auto_ss;
          end else begin
            ss_n_q <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise) begin
            sclk_q <= 1'b1;
          end else if (fall) begin
            sclk_q <= 1'b0;
            if (end_burst) begin
              state_q    <= ST_GAP;
              ss_n_q     <= 1'b1;
              gap_half_q <= 1'b0;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half_q) begin
              state_q <= ST_IDLE;
            end
            gap_half_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk         = sclk_q;
  assign ss_n         = ss_n_q;
  assign ss_oe        = cfg_auto_ss;
  assign busy         = (state_q != ST_IDLE) || hold_full_q;
  assign tx_empty_irq = irq_q;
endmodule

// File: rtl/spi_dbm_checker.sv
module spi_dbm_checker (
  input logic clk,
  input logic rst,
  input logic cfg_auto_ss,
  input logic tx_wr,
  input logic rx_rd,
  input logic sclk,
  input logic dout,
  input logic ss_n,
  input logic tx_empty_irq,
  input logic rx_ready,
  input logic rx_overflow
);
  AST_DOUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(dout)); // R1

  AST_MANUAL_SS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!cfg_auto_ss && !$past(cfg_auto_ss)) |-> ss_n); // R4

  AST_DESELECT_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    (cfg_auto_ss && ss_n) |-> !sclk); // R6

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_empty_irq); // R7

  AST_READ_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> !rx_overflow); // R9

  AST_OVF_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |-> rx_ready); // R9
endmodule

bind spi_dbuf_master spi_dbm_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_auto_ss  (cfg_auto_ss),
  .tx_wr        (tx_wr),
  .rx_rd        (rx_rd),
  .sclk         (sclk),
  .dout         (dout),
  .ss_n         (ss_n),
  .tx_empty_irq (tx_empty_irq),
  .rx_ready     (rx_ready),
  .rx_overflow  (rx_overflow)
);

// File: tb/spi_dbuf_master_tb.sv
module spi_dbuf_master_tb;
  localparam int DW = 8;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cont = 1'b0;
  logic cfg_auto_ss = 1'b1;
  logic [VW-1:0] cfg_div = '0;
  logic tx_wr = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic rx_rd = 1'b0;
  logic din = 1'b0;
  logic sclk, dout, ss_n, ss_oe, busy, tx_empty_irq, rx_ready, rx_overflow;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Shared state.
  logic [DW-1:0] exp_tx [0:1023];
  int wr_idx = 0;
  int chk_idx = 0;
  int sl_idx = 0;
  int bitn = 0;
  int hp_bad = 0, hp_last = 0;
  int gap_bad = 0, gap_last = 0;
  int r4_bad = 0;
  int ss_rises = 0;
  int rd_cnt = 0;
  int rd_offset = 0;
  bit rd_en = 1'b1;

  always #2 clk = ~clk;

  spi_dbuf_master #(.DATA_W(DW), .DIV_W(VW)) u_dut (
    .clk(clk), .rst(rst), .cfg_cont(cfg_cont), .cfg_auto_ss(cfg_auto_ss),
    .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .din(din), .sclk(sclk), .dout(dout), .ss_n(ss_n), .ss_oe(ss_oe),
    .busy(busy), .tx_empty_irq(tx_empty_irq), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_overflow(rx_overflow)
  );

  function automatic logic [DW-1:0] sl_byte(input int n);
    return DW'((n * 73 + 29) ^ (n >> 2));
  endfunction

  function automatic int half_cycles();
    return int'(cfg_div) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slave model and timing monitor.
  initial begin
    logic prev_sclk, prev_ss, prev_final, have_edge, busy_low_seen, seen_fall;
    logic [DW-1:0] mosi;
    int cyc, hi_cnt;
    prev_sclk = 0; prev_ss = 1; prev_final = 0; have_edge = 0;
    busy_low_seen = 1; seen_fall = 0; mosi = '0; cyc = 0; hi_cnt = 0;
    din = sl_byte(0)[DW-1];
    forever begin
      @(negedge clk);
      if (!rst) begin
        cyc++;
        if (!cfg_auto_ss && ss_n !== 1'b1) r4_bad++;
        if (sclk !== prev_sclk) begin
          if (have_edge && !(prev_final && (!cfg_cont || busy_low_seen))) begin
            if (cyc != half_cycles()) begin hp_bad++; hp_last = cyc; end
          end
          have_edge = 1; cyc = 0; busy_low_seen = 0;
          if (sclk) begin
            mosi = {mosi[DW-2:0], dout};
            bitn++;
            prev_final = 0;
            if (bitn == DW) begin
              // R1: eight bits, MSB first
              chk(mosi == exp_tx[chk_idx], "R1", int'(mosi), int'(exp_tx[chk_idx]));
              chk_idx++; bitn = 0; sl_idx++;
            end
            din = sl_byte(sl_idx)[DW-1-bitn];
          end else begin
            prev_final = (bitn == 0);
          end
          prev_sclk = sclk;
        end
        if (!busy) busy_low_seen = 1;
        if (prev_ss == 1'b0 && ss_n == 1'b1) ss_rises++;
        if (ss_n == 1'b1) hi_cnt++;
        if (prev_ss == 1'b1 && ss_n == 1'b0) begin
          if (seen_fall && cfg_auto_ss && !cfg_cont && hi_cnt < 2 * half_cycles()) begin
            gap_bad++; gap_last = hi_cnt;
          end
          seen_fall = 1; hi_cnt = 0;
        end
        prev_ss = ss_n;
      end
    end
  end

  // Receive reader.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_en && rx_ready && !rx_rd && !rst) begin
        // R8: received byte in order
        chk(rx_data == sl_byte(rd_cnt + rd_offset), "R8", int'(rx_data),
            int'(sl_byte(rd_cnt + rd_offset)));
        rd_cnt++;
        rx_rd = 1'b1;
      end else begin
        rx_rd = 1'b0;
      end
    end
  end

  task automatic write_byte(input logic [DW-1:0] b);
    tx_data = b; tx_wr = 1'b1;
    exp_tx[wr_idx] = b; wr_idx++;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic send_stream(input int n);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        while (!tx_empty_irq) @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
      end
      write_byte(DW'($urandom));
    end
    wait_idle();
  endtask

  initial begin
    int hp0, gp0, r40, ss0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(ss_n == 1'b1, "R10 ss_n", int'(ss_n), 1);
    chk(sclk == 1'b0 && dout == 1'b0, "R10 sclk/dout", int'({sclk, dout}), 0);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk({tx_empty_irq, rx_ready, rx_overflow} == 3'b000, "R10 flags",
        int'({tx_empty_irq, rx_ready, rx_overflow}), 0);

    // Per-byte stream to leave tx_empty_irq set.
    cfg_cont = 0; cfg_auto_ss = 1; cfg_div = 1;
    ss0 = ss_rises; gp0 = gap_bad;
    send_stream(4);
    chk(ss_rises - ss0 == 4, "R6 rises", ss_rises - ss0, 4);
    chk(gap_bad == gp0, "R6 gap", gap_last, 2 * half_cycles());

    // Directed start timing (R3, R7, R11, R2).
    cfg_div = 2;
    chk(tx_empty_irq == 1'b1, "R7 set after move", int'(tx_empty_irq), 1);
    write_byte(8'hA5);
    chk(tx_empty_irq == 1'b0, "R7 cleared by write", int'(tx_empty_irq), 0);
    chk(ss_n == 1'b1, "R3 ss_n one edge after write", int'(ss_n), 1);
    chk(busy == 1'b1, "R11 busy after write", int'(busy), 1);
    @(negedge clk);
    chk(ss_n == 1'b0, "R3 ss_n low two edges after write", int'(ss_n), 0);
    chk(dout == 1'b1, "R3 dout msb", int'(dout), 1);
    chk(tx_empty_irq == 1'b1, "R7 set on move", int'(tx_empty_irq), 1);
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R2 sclk low before half period", int'(sclk), 0);
    @(negedge clk);
    chk(sclk == 1'b1, "R2 sclk rises after half period", int'(sclk), 1);
    wait_idle();
    chk(busy == 1'b0, "R11 busy clear when idle", int'(busy), 0);

    // Random mix of modes.
    for (int it = 0; it < 8; it++) begin
      int n;
      bit c;
      c = 1'($urandom % 2);
      n = 2 + int'($urandom % 5);
      cfg_cont = c; cfg_auto_ss = 1; cfg_div = VW'($urandom % 4);
      hp0 = hp_bad; gp0 = gap_bad; ss0 = ss_rises;
      send_stream(n);
      if (c) chk(ss_rises - ss0 == 1, "R5 one rise per burst", ss_rises - ss0, 1);
      else   chk(ss_rises - ss0 == n, "R6 one rise per byte", ss_rises - ss0, n);
      chk(hp_bad == hp0, "R2 half period", hp_last, half_cycles());
      chk(gap_bad == gp0, "R6 deselect length", gap_last, 2 * half_cycles());
    end

    // Streaming at the fastest divider.
    cfg_cont = 1; cfg_div = 0;
    hp0 = hp_bad; ss0 = ss_rises;
    send_stream(5);
    chk(ss_rises - ss0 == 1, "R5 fast burst", ss_rises - ss0, 1);
    chk(hp_bad == hp0, "R5 no clock break", hp_last, half_cycles());

    // Manual slave select.
    cfg_auto_ss = 0; cfg_cont = 1; cfg_div = 1;
    r40 = r4_bad; ss0 = ss_rises;
    @(negedge clk);
    chk(ss_oe == 1'b0, "R4 ss_oe", int'(ss_oe), 0);
    send_stream(3);
    chk(r4_bad == r40, "R4 ss_n held high", r4_bad - r40, 0);
    chk(ss_rises == ss0, "R4 no ss edges", ss_rises - ss0, 0);
    cfg_auto_ss = 1;

    // Overflow.
    rd_en = 0; cfg_cont = 0; cfg_div = 0;
    send_stream(2);
    chk(rx_overflow == 1'b1, "R9 overflow set", int'(rx_overflow), 1);
    chk(rx_ready == 1'b1, "R9 ready kept", int'(rx_ready), 1);
    chk(rx_data == sl_byte(sl_idx - 1), "R9 newest byte kept", int'(rx_data),
        int'(sl_byte(sl_idx - 1)));
    rd_offset = rd_offset + 1;
    rd_en = 1;
    repeat (3) @(negedge clk);
    chk(rx_overflow == 1'b0, "R9 overflow cleared by read", int'(rx_overflow), 0);
    chk(rx_ready == 1'b0, "R8 ready cleared by read", int'(rx_ready), 0);

    chk(chk_idx == wr_idx, "R1 all bytes shifted", chk_idx, wr_idx);
    chk(rd_cnt + rd_offset == sl_idx, "R8 all bytes received", rd_cnt + rd_offset, sl_idx);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule